// File: doc/BRIEF.md
# Edge-Select Input Capture Unit

This block records when chosen transitions happen on a small group of input pins. A free-running timestamp counter advances once every few system clocks, with the spacing set by a programmable divider. Each channel watches one pin through a two-flop synchronizer. When the transition picked for that channel appears (rising, falling, either, or none), the channel stores the current timestamp and sets a pending flag. Software measures pulse widths and periods by reprogramming the edge choice between captures and subtracting the stored timestamps.

Software drives the unit through a plain word-addressed register port: a single write strobe with address and data, and a read-data output that is registered from the address. Pending flags are masked by per-channel interrupt enables and ORed into one registered interrupt line. They clear only through writes to a separate acknowledge register.

Top module: `edge_capture_unit`

## Requirements
- R1: After synchronous reset every register reads zero, `irq_o` is 0 and `reg_rdata` is 0.
- R2: The edge register of channel x sits at byte address 0x30+4*x, bits 1:0. Code 0 ignores the pin, 1 captures rising edges, 2 captures falling edges and 3 captures both.
- R3: A pin change is seen through two synchronizing flops. The value stored is the timestamp held during the cycle after the second rising clock edge that follows the change, so it is written on the third edge.
- R4: Control register 0x50 holds a divider P in bits 8:4 and the global enable in bit 10. While enabled, the 32-bit timestamp advances by one every P+1 clocks and wraps at its maximum. While disabled, it is held at zero.
- R5: The stored value of channel x is read at 0x10+4*x. A later capture overwrites it.
- R6: A capture sets the pending flag of channel x, readable at bit x+1 of 0x58. The flag stays set until it is acknowledged.
- R7: Writing 0x5C clears the pending flag of channel x when data bit x+1 is 1, so 0x1FF clears all of them. A capture in the same cycle as its acknowledge leaves the flag set.
- R8: Interrupt enables sit at bits 4:1 of 0x54, with bit x+1 for channel x. `irq_o` is registered, and is 1 one cycle after any pending flag whose enable is set.
- R9: With the global enable clear or the edge code 0, pin changes change neither the stored value nor the pending flag.
- R10: `reg_rdata` shows the register addressed in the previous cycle. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | NCH | Asynchronous pins being timestamped |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Random runs pick a channel, an edge code, a divider value, a delay and the pin's current level. A matching edge has to yield the exact timestamp predicted from the cycle count, while a mismatched edge must leave the old value and a clear flag. This separates the four edge codes and shows any off-by-one in the divider or the synchronizer. Directed cases run both-edge overwrite, partial and same-cycle acknowledge, capture while disabled, and interrupt masking. Together they tell flag-set priority apart from flag-clear, and masking apart from flag state.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam logic [7:0] VAL_BASE  = 8'h10;
  localparam logic [7:0] EDGE_BASE = 8'h30;
  localparam logic [7:0] CTRL_ADDR = 8'h50;
  localparam logic [7:0] IE_ADDR   = 8'h54;
  localparam logic [7:0] STAT_ADDR = 8'h58;
  localparam logic [7:0] ACK_ADDR  = 8'h5C;
  localparam int         RUN_BIT   = 10;
  localparam int         PSC_LSB   = 4;
endpackage

// File: rtl/ecu_timebase.sv
module ecu_timebase #(
  parameter int PSW = 5,
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [PSW-1:0] psc,
  output logic [TSW-1:0] ts
);
  logic [PSW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      ts    <= '0;
    end else if (div_q == psc) begin
      div_q <= '0;
      ts    <= ts + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
  import ecu_pkg::*;
#(
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pin,
  input  logic           run,
  input  logic [1:0]     mode,
  input  logic [TSW-1:0] ts,
  input  logic           ack,
  output logic [TSW-1:0] value,
  output logic           pend
);
  logic s1, s2, s3;
  logic rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb begin
    case (edge_mode_e'(mode))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    hit = hit & run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      pend  <= 1'b0;
    end else begin
      if (hit) value <= ts;
      if (hit)      pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PSW = 5,
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cap_in,
  input  logic           reg_wr,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq_o
);
  localparam int PSC_MSB = PSC_LSB + PSW - 1;

  logic           en_q;
  logic [PSW-1:0] psc_q;
  logic [NCH-1:0] ie_q;
  logic [1:0]     mode_q [NCH];
  logic [TSW-1:0] ts;
  logic [TSW-1:0] val_w  [NCH];
  logic [NCH-1:0] stat_all;
  logic [NCH-1:0] ack_v;
  logic [31:0]    rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      psc_q <= '0;
      ie_q  <= '0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= 2'b00;
    end else if (reg_wr) begin
      if (reg_addr == CTRL_ADDR) begin
        en_q  <= reg_wdata[RUN_BIT];
        psc_q <= reg_wdata[PSC_MSB:PSC_LSB];
      end
      if (reg_addr == IE_ADDR) ie_q <= reg_wdata[NCH:1];
      for (int i = 0; i < NCH; i++)
        if (reg_addr == 8'(EDGE_BASE + 4 * i)) mode_q[i] <= reg_wdata[1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      ack_v[i] = reg_wr && (reg_addr == ACK_ADDR) && reg_wdata[i+1];
  end

  ecu_timebase #(.PSW(PSW), .TSW(TSW)) u_tb (
    .clk(clk), .rst(rst), .run(en_q), .psc(psc_q), .ts(ts)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ecu_channel #(.TSW(TSW)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .pin  (cap_in[g]),
      .run  (en_q),
      .mode (mode_q[g]),
      .ts   (ts),
      .ack  (ack_v[g]),
      .value(val_w[g]),
      .pend (stat_all[g])
    );
  end

  always_comb begin
    rd_d = '0;
    if (reg_addr == CTRL_ADDR) begin
      rd_d[RUN_BIT]         = en_q;
      rd_d[PSC_MSB:PSC_LSB] = psc_q;
    end
    if (reg_addr == IE_ADDR)   rd_d[NCH:1] = ie_q;
    if (reg_addr == STAT_ADDR) rd_d[NCH:1] = stat_all;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == 8'(VAL_BASE + 4 * i))  rd_d[TSW-1:0] = val_w[i];
      if (reg_addr == 8'(EDGE_BASE + 4 * i)) rd_d[1:0]     = mode_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      reg_rdata <= rd_d;
      irq_o     <= |(stat_all & ie_q);
    end
  end
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int NCH = 4,
  parameter int TSW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic [TSW-1:0] ts,
  input logic [NCH-1:0] stat,
  input logic           irq
);
  // R4
  stopped_ts_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (ts == '0));

  // R4
  ts_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (ts == $past(ts) || ts == $past(ts) + 1'b1));

  // R9
  no_capture_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & ~$past(stat))) |-> $past(run));

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|stat));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && stat == '0 && ts == '0));
endmodule

bind edge_capture_unit ecu_checker #(.NCH(NCH), .TSW(TSW)) u_chk (
  .clk (clk),
  .rst (rst),
  .run (en_q),
  .ts  (ts),
  .stat(stat_all),
  .irq (irq_o)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  localparam int NCH = 4;
  localparam logic [7:0] A_CTRL = 8'h50, A_IE = 8'h54, A_STAT = 8'h58, A_ACK = 8'h5C;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] cap_in = '0;
  logic           reg_wr = 1'b0;
  logic [7:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           irq_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int e0 = 0;
  int cur_p = 0;
  int last_a = 0;
  logic [31:0] model_val [NCH];
  logic [31:0] rd;

  edge_capture_unit #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .cap_in(cap_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] exp_cap(int a, int p);
    return 32'((a + 2) / (p + 1));
  endfunction

  function automatic bit edge_hits(int mode, bit rising);
    return (mode == 3) || (mode == 1 && rising) || (mode == 2 && !rising);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start(int p);
    wr(A_CTRL, 32'h0);
    cur_p = p;
    wr(A_CTRL, (32'd1 << 10) | (32'(p) << 4));
    e0 = cyc;
  endtask

  task automatic toggle(int ch);
    cap_in[ch] = ~cap_in[ch];
    last_a = cyc - e0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) model_val[i] = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rdreg(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
    rdreg(A_STAT, rd); check("R1 stat", rd, 32'h0);
    rdreg(8'h10, rd);  check("R1 val0", rd, 32'h0);

    // R10 unmapped address
    rdreg(8'h4C, rd); check("R10 unmapped", rd, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rdreg(A_CTRL, rd); check("R10 ctrl unused bits", rd, 32'h0000_05F0);
    wr(A_CTRL, 32'h0);

    // R2 R5 both edges overwrite on channel 1
    wr(8'h34, 32'd3);
    rdreg(8'h34, rd); check("R2 edge readback", rd, 32'd3);
    start(2);
    idle(4); toggle(1); idle(6);
    model_val[1] = exp_cap(last_a, cur_p);
    rdreg(8'h14, rd); check("R3 rising capture", rd, model_val[1]);
    idle(5); toggle(1); idle(6);
    model_val[1] = exp_cap(last_a, cur_p);
    rdreg(8'h14, rd); check("R5 falling overwrite", rd, model_val[1]);
    rdreg(A_STAT, rd); check("R6 flag set", rd, 32'h04);

    // R7 ack in same cycle as capture keeps flag
    wr(A_ACK, 32'h1FF);
    rdreg(A_STAT, rd); check("R7 ack all", rd, 32'h0);
    toggle(1); idle(2);
    wr(A_ACK, 32'h1FF);
    rdreg(A_STAT, rd); check("R7 capture beats ack", rd, 32'h04);
    model_val[1] = exp_cap(last_a, cur_p);
    wr(A_ACK, 32'h1FF);

    // R7 partial ack: channels 0 and 2
    wr(8'h30, 32'd1); wr(8'h38, 32'd1);
    start(0);
    toggle(0); toggle(2); idle(6);
    model_val[0] = exp_cap(last_a, cur_p);
    model_val[2] = exp_cap(last_a, cur_p);
    rdreg(A_STAT, rd); check("R6 two flags", rd, 32'h0A);
    wr(A_ACK, 32'h002);
    rdreg(A_STAT, rd); check("R7 partial ack", rd, 32'h08);

    // R8 masking then enabling
    check("R8 masked irq", {31'b0, irq_o}, 32'h0);
    wr(A_IE, 32'h08); idle(1);
    check("R8 irq raised", {31'b0, irq_o}, 32'h1);
    wr(A_ACK, 32'h1FF); idle(1);
    check("R8 irq dropped", {31'b0, irq_o}, 32'h0);

    // R9 disabled globally: falling edge on ch0 with mode 3 ignored
    wr(8'h30, 32'd3);
    wr(A_CTRL, 32'h0);
    toggle(0); idle(6);
    rdreg(8'h10, rd); check("R9 stopped value", rd, model_val[0]);
    rdreg(A_STAT, rd); check("R9 stopped flag", rd, 32'h0);
    // R9 mode 0 ignored while running
    wr(8'h30, 32'd0);
    start(1);
    idle(3); toggle(0); idle(6);
    rdreg(8'h10, rd); check("R9 mode off value", rd, model_val[0]);
    rdreg(A_STAT, rd); check("R9 mode off flag", rd, 32'h0);

    // R2 R3 R4 random sweep
    for (int it = 0; it < 60; it++) begin
      int ch, mode, p, dly;
      bit rising, hit;
      logic [31:0] ev;
      ch = $urandom_range(0, NCH - 1);
      mode = $urandom_range(0, 3);
      p = $urandom_range(0, 31);
      dly = $urandom_range(0, 40);
      for (int k = 0; k < NCH; k++) wr(8'(8'h30 + 4 * k), 32'd0);
      wr(8'(8'h30 + 4 * ch), 32'(mode));
      wr(A_IE, 32'(1) << (ch + 1));
      wr(A_ACK, 32'h1FF);
      start(p);
      idle(dly);
      rising = !cap_in[ch];
      toggle(ch); idle(6);
      hit = edge_hits(mode, rising);
      if (hit) model_val[ch] = exp_cap(last_a, cur_p);
      ev = hit ? (32'(1) << (ch + 1)) : 32'h0;
      rdreg(8'(8'h10 + 4 * ch), rd); check("R4 random value", rd, model_val[ch]);
      rdreg(A_STAT, rd); check("R2 random flag", rd, ev);
      check("R8 random irq", {31'b0, irq_o}, {31'b0, hit});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule